// File: doc/BRIEF.md
# I2C Master Clock Period Generator

This block produces the SCL waveform of an I2C master from programmed cycle counts, running on the controller clock. Two count pairs are held outside the block, one for standard mode and one for fast mode, and a select input picks which pair shapes the next bit period. The generator drives SCL through an open-drain enable. Each low phase starts the cycle the block begins pulling the line down and does not wait for the line to be seen low. The high phase is timed only after the released line is seen high through a two-stage synchronizer, so a slave that stretches the clock lengthens the high phase.

The bit engine uses two single-cycle strobes to place SDA changes and samples. One marks the first cycle of each low phase. The other marks the cycle the high count starts. The programmed counts do not give the phase lengths directly. A low phase lasts its count plus one cycle. When nothing stretches the clock, a high phase lasts its count plus eight cycles, and three of those eight cover the release and synchronizer delay. Both counts are raised to a floor before use. With a 0.3 us fall-time allowance, a driver can compute counts for 4.0 us high / 4.7 us low in standard mode and 0.6 us high / 1.3 us low in fast mode.

Top module: `scl_period_gen`

## Requirements
- R1: While `rst_n` is low, and while `enable` is low with the block idle, `scl_pull_low` is 0 and neither strobe is asserted.
- R2: A low phase keeps `scl_pull_low` at 1 for exactly low count + 1 consecutive cycles. `low_begin` is 1 on its first cycle, and `scl_pull_low` never rises without `low_begin`.
- R3: If the line rises as soon as it is released, the released (high) phase lasts exactly high count + 8 cycles, counted from the first cycle `scl_pull_low` is 0 up to the cycle before it returns to 1.
- R4: With `fast_mode` = 0 the standard-mode counts (`std_high`, `std_low`) are used. With `fast_mode` = 1 the fast-mode counts (`fast_high`, `fast_low`) are used.
- R5: A high count below 6 behaves as 6 and a low count below 8 behaves as 8. Values at the floor are used unchanged. No low phase ended by its counter is shorter than 9 cycles.
- R6: The high count starts only after `scl_in` has been high for a full cycle and has passed the two synchronizer stages. `high_begin` is 1 on the third cycle after the first cycle in which `scl_in` is sampled high. A stretch of S extra low cycles lengthens the released phase to high count + 8 + S.
- R7: The mode select and all four counts are sampled only on the cycle before a low phase starts. A change during a period affects only the next period.
- R8: Deasserting `enable` releases SCL on the next cycle, and the block stays released with no strobes. Reasserting `enable` from idle starts a low phase on the next cycle.
- R9: `low_begin` and `high_begin` are never asserted together. Each phase produces exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Runs the generator; when low SCL is released |
| fast_mode | input | 1 | 0 selects standard-mode counts, 1 selects fast-mode counts |
| std_high | input | 16 | Standard-mode high count |
| std_low | input | 16 | Standard-mode low count |
| fast_high | input | 16 | Fast-mode high count |
| fast_low | input | 16 | Fast-mode low count |
| scl_in | input | 1 | Sensed SCL line level (asynchronous) |
| scl_pull_low | output | 1 | Open-drain enable: 1 pulls SCL low |
| low_begin | output | 1 | Strobe on the first cycle of each low phase |
| high_begin | output | 1 | Strobe on the cycle the high count starts |

## Verification
The checker watches these on every cycle: SCL is released after `enable` falls, every rise of the pull-low enable comes with its strobe, no low phase ended by its counter is shorter than the clamped floor, each high strobe follows a line that was sampled high three cycles earlier, and the two strobes are never asserted together. Some properties are only shown by the bench scenarios. These are the exact low and high lengths for each count set, the clamp values at and below the floor, the length added by stretching, and the rule that mode and count changes wait for the next low phase. Each of these depends on the programmed values and on the order of the stimulus.

// File: rtl/scl_period_pkg.sv
package scl_period_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scl_cnt_select.sv
module scl_cnt_select #(
  parameter int CW     = 16,
  parameter int MIN_HI = 6,
  parameter int MIN_LO = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          fast_mode,
  input  logic [CW-1:0] std_high,
  input  logic [CW-1:0] std_low,
  input  logic [CW-1:0] fast_high,
  input  logic [CW-1:0] fast_low,
  output logic [CW-1:0] hi_cnt,
  output logic [CW-1:0] lo_cnt
);
  localparam logic [CW-1:0] HI_FLOOR = CW'(MIN_HI);
  localparam logic [CW-1:0] LO_FLOOR = CW'(MIN_LO);

  logic [CW-1:0] hi_raw, lo_raw, hi_clamp, lo_clamp;
  logic [CW-1:0] hi_d, lo_d;

  always_comb begin
    hi_raw   = fast_mode ? fast_high : std_high;
    lo_raw   = fast_mode ? fast_low  : std_low;
    hi_clamp = (hi_raw < HI_FLOOR) ? HI_FLOOR : hi_raw;
    lo_clamp = (lo_raw < LO_FLOOR) ? LO_FLOOR : lo_raw;
    hi_d     = load ? hi_clamp : hi_cnt;
    lo_d     = load ? lo_clamp : lo_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= HI_FLOOR;
      lo_cnt <= LO_FLOOR;
    end else begin
      hi_cnt <= hi_d;
      lo_cnt <= lo_d;
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_period_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HIGH_OVH    = 8,
  parameter int LOW_OVH     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          line_high,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  output logic          load_req,
  output logic          pull_low,
  output logic          low_strb,
  output logic          high_strb
);
  localparam int TW = CW + 2;
  // Release cycle plus synchronizer stages are spent before HIGH is entered.
  localparam int HI_ADJ = HIGH_OVH - SYNC_STAGES - 2;
  localparam int LO_ADJ = LOW_OVH - 1;

  phase_t        state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [TW-1:0] hi_term, lo_term;
  logic          pull_d, low_strb_d, high_strb_d;

  always_comb begin
    hi_term = TW'(hi_cnt) + TW'(HI_ADJ);
    lo_term = TW'(lo_cnt) + TW'(LO_ADJ);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        state_d = PH_LOW;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      PH_LOW: begin
        cnt_en = 1'b1;
        if (cnt_q == lo_term) begin
          state_d = PH_WAIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WAIT: begin
        if (line_high) begin
          state_d = PH_HIGH;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      PH_HIGH: begin
        cnt_en = 1'b1;
        if (cnt_q == hi_term) begin
          state_d = PH_LOW;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = PH_IDLE;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
    endcase
    if (!enable) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end
  end

  always_comb begin
    load_req    = (state_d == PH_LOW)  && (state_q != PH_LOW);
    pull_d      = (state_d == PH_LOW);
    low_strb_d  = load_req;
    high_strb_d = (state_d == PH_HIGH) && (state_q != PH_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_IDLE;
      pull_low  <= 1'b0;
      low_strb  <= 1'b0;
      high_strb <= 1'b0;
    end else begin
      state_q   <= state_d;
      pull_low  <= pull_d;
      low_strb  <= low_strb_d;
      high_strb <= high_strb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HIGH_OVH    = 8,
  parameter int LOW_OVH     = 1,
  parameter int MIN_HI      = 6,
  parameter int MIN_LO      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          fast_mode,
  input  logic [CW-1:0] std_high,
  input  logic [CW-1:0] std_low,
  input  logic [CW-1:0] fast_high,
  input  logic [CW-1:0] fast_low,
  input  logic          scl_in,
  output logic          scl_pull_low,
  output logic          low_begin,
  output logic          high_begin
);
  logic          line_high;
  logic          load_req;
  logic [CW-1:0] hi_cnt, lo_cnt;

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (scl_in),
    .q    (line_high)
  );

  scl_cnt_select #(.CW(CW), .MIN_HI(MIN_HI), .MIN_LO(MIN_LO)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_req),
    .fast_mode(fast_mode),
    .std_high (std_high),
    .std_low  (std_low),
    .fast_high(fast_high),
    .fast_low (fast_low),
    .hi_cnt   (hi_cnt),
    .lo_cnt   (lo_cnt)
  );

  scl_phase_fsm #(
    .CW(CW), .SYNC_STAGES(SYNC_STAGES), .HIGH_OVH(HIGH_OVH), .LOW_OVH(LOW_OVH)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .line_high(line_high),
    .hi_cnt   (hi_cnt),
    .lo_cnt   (lo_cnt),
    .load_req (load_req),
    .pull_low (scl_pull_low),
    .low_strb (low_begin),
    .high_strb(high_begin)
  );
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk #(
  parameter int MIN_LO  = 8,
  parameter int LOW_OVH = 1
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_in,
  input logic scl_pull_low,
  input logic low_begin,
  input logic high_begin
);
  logic [31:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run_q <= '0;
    else if (scl_pull_low) low_run_q <= low_run_q + 1'b1;
    else                   low_run_q <= '0;
  end

  assert_release_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_pull_low);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!low_begin && !high_begin));

  assert_low_has_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> low_begin);

  assert_strobe_in_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    low_begin |-> scl_pull_low);

  assert_min_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull_low) && $past(enable)) |-> (low_run_q >= 32'(MIN_LO + LOW_OVH)));

  assert_high_after_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    high_begin |-> (!scl_pull_low && $past(scl_in, 3)));

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_begin, high_begin}));
endmodule

bind scl_period_gen scl_period_gen_chk #(.MIN_LO(MIN_LO), .LOW_OVH(LOW_OVH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .scl_in      (scl_in),
  .scl_pull_low(scl_pull_low),
  .low_begin   (low_begin),
  .high_begin  (high_begin)
);

// File: tb/scl_period_gen_test.sv
module scl_period_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        fast_mode;
  logic [15:0] std_high, std_low, fast_high, fast_low;
  logic        hold_low;
  logic        scl_in;
  logic        scl_pull_low, low_begin, high_begin;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  assign scl_in = ~scl_pull_low & ~hold_low;

  scl_period_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
    .std_high(std_high), .std_low(std_low), .fast_high(fast_high), .fast_low(fast_low),
    .scl_in(scl_in), .scl_pull_low(scl_pull_low), .low_begin(low_begin), .high_begin(high_begin)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measures one full period, starting at the next low strobe (sampled on negedges).
  task automatic measure(output int lo, output int hi, output int hs_at, output int strobes,
                         input int stretch, input bit flip);
    strobes = 0;
    while (!low_begin) @(negedge clk);
    if (stretch > 0) hold_low = 1'b1;
    lo = 1;
    @(negedge clk);
    while (scl_pull_low) begin
      lo++;
      if (low_begin) strobes++;
      if (flip && lo == 5) begin
        fast_mode = 1'b1;
        std_high  = 16'd99;
      end
      @(negedge clk);
    end
    hi = 0; hs_at = 0;
    while (!scl_pull_low) begin
      hi++;
      if (high_begin) begin hs_at = hi; strobes++; end
      if (stretch > 0 && hi == stretch + 1) hold_low = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic stop_gen();
    @(negedge clk) enable = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    int bad = 0;
    rst_n = 1'b0; enable = 1'b0; fast_mode = 1'b0; hold_low = 1'b0;
    std_high = 16'd20; std_low = 16'd30; fast_high = 16'd10; fast_low = 16'd12;
    repeat (3) @(negedge clk) if (scl_pull_low || low_begin || high_begin) bad++;
    rst_n = 1'b1;
    repeat (10) @(negedge clk) if (scl_pull_low || low_begin || high_begin) bad++;
    check("R1 idle outputs quiet", bad, 0);
  endtask

  task automatic t_standard();
    int lo, hi, hs, st;
    fast_mode = 1'b0; std_high = 16'd20; std_low = 16'd30;
    @(negedge clk) enable = 1'b1;
    measure(lo, hi, hs, st, 0, 1'b0);
    check("R2 std low length", lo, 31);
    check("R3 std high length", hi, 28);
    check("R6 high strobe position", hs, 4);
    check("R9 one strobe per phase", st, 1);
    measure(lo, hi, hs, st, 0, 1'b0);
    check("R2 std low second period", lo, 31);
    check("R3 std high second period", hi, 28);
    stop_gen();
  endtask

  task automatic t_fast();
    int lo, hi, hs, st;
    fast_mode = 1'b1; fast_high = 16'd10; fast_low = 16'd12;
    @(negedge clk) enable = 1'b1;
    measure(lo, hi, hs, st, 0, 1'b0);
    check("R4 fast low length", lo, 13);
    check("R4 fast high length", hi, 18);
    stop_gen();
  endtask

  task automatic t_clamp(input int h, input int l);
    int lo, hi, hs, st;
    fast_mode = 1'b1; fast_high = 16'(h); fast_low = 16'(l);
    @(negedge clk) enable = 1'b1;
    measure(lo, hi, hs, st, 0, 1'b0);
    check("R5 clamped low length", lo, 9);
    check("R5 clamped high length", hi, 14);
    stop_gen();
  endtask

  task automatic t_stretch();
    int lo, hi, hs, st;
    fast_mode = 1'b0; std_high = 16'd20; std_low = 16'd30;
    @(negedge clk) enable = 1'b1;
    measure(lo, hi, hs, st, 15, 1'b0);
    check("R6 stretched high length", hi, 43);
    check("R6 stretched strobe position", hs, 19);
    check("R9 one strobe while stretched", st, 1);
    stop_gen();
  endtask

  task automatic t_mode_change();
    int lo, hi, hs, st;
    fast_mode = 1'b0; std_high = 16'd20; std_low = 16'd30;
    fast_high = 16'd10; fast_low = 16'd12;
    @(negedge clk) enable = 1'b1;
    measure(lo, hi, hs, st, 0, 1'b1);
    check("R7 low kept after mid-period change", lo, 31);
    check("R7 high kept after mid-period change", hi, 28);
    measure(lo, hi, hs, st, 0, 1'b0);
    check("R7 new low next period", lo, 13);
    check("R7 new high next period", hi, 18);
    stop_gen();
    fast_mode = 1'b0; std_high = 16'd20;
  endtask

  task automatic t_disable();
    int bad = 0;
    fast_mode = 1'b0;
    @(negedge clk) enable = 1'b1;
    while (!low_begin) @(negedge clk);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R8 released next cycle", int'(scl_pull_low), 0);
    repeat (20) @(negedge clk) if (scl_pull_low || low_begin || high_begin) bad++;
    check("R8 stays released", bad, 0);
    enable = 1'b1;
    @(negedge clk);
    check("R8 restart low strobe", int'(low_begin), 1);
    check("R8 restart pulls low", int'(scl_pull_low), 1);
    stop_gen();
  endtask

  initial begin
    #3000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_standard();
    t_fast();
    t_clamp(2, 3);
    t_clamp(6, 8);
    t_stretch();
    t_mode_change();
    t_disable();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule